// File: doc/BRIEF.md
# Paged Audio Delay Line over a Serial SRAM

This block holds a long mono delay line in an external serial SRAM reached over SPI. Samples arrive one per strobe and are gathered into an on-chip page of eight. Each full page goes out to the SRAM as a single burst write. The burst opens with a command word: an opcode, then a byte address taken from a running page counter. After the write, the block issues a burst read of the page stored a programmed number of pages earlier. That page lands in an output page buffer and is played back one sample per strobe.

Each samples is 24 bits wide and is stored as a 32-bit word whose low byte is zero padding. This gives 32 bytes per page and 2048 pages in a 64 KiB address space. Both the input and the output page buffers are ping-pong pairs. This lets samples keep flowing at the audio rate while an SPI burst is in progress. The SPI clock is half the system clock. The sample period must be long enough for a write burst, a read burst and both chip-select gaps to finish within eight sample periods.

Top module: `sde_delay_engine`

## Requirements
- R1: While `rst` is high, `smp_out` is 0, `underrun` is 0, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0.
- R2: The SPI port works in mode 0. SCK is low whenever CS is high, and MOSI changes only while SCK is low. The slave samples MOSI on the rising edge, and MISO is sampled at the end of the high phase.
- R3: Every command shifts out exactly 280 bits, MSB first. These are an 8-bit opcode (0x02 = write, 0x03 = read), a 16-bit byte address, and then eight 32-bit data words.
- R4: Sample j of page p is held at byte address 32*p + 4*j. Its bytes are stored in the order bits 23:16, 15:8, 7:0, then a padding byte of 0x00.
- R5: Write commands carry page addresses 0, 32, 64, and so on. The address advances by 32 bytes per completed input page and wraps modulo 65536.
- R6: With `delay_pages` = D, a read of address 32*(p-D) mod 65536 follows the write of page p directly, for every p >= D. No read is issued for the first D pages.
- R7: Between two commands, CS stays high for at least GAP_CYC clock cycles.
- R8: `smp_out` is updated only in the clock cycle that samples `smp_stb`. From strobe number 8*(D+2) onward, the output at strobe k equals the input given at strobe k-8*(D+2).
- R9: `smp_out` is 0 until the first delayed page begins to play.
- R10: `underrun` pulses for one cycle with a strobe when playback has started but the current output page holds no valid data. It never pulses before the first page plays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe, one per audio sample period |
| smp_in | input | 24 | Input sample, taken on the strobe |
| delay_pages | input | 11 | Delay in pages; change only while in reset |
| smp_out | output | 24 | Delayed output sample |
| underrun | output | 1 | One-cycle pulse: strobe with no valid output sample |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data to the SRAM |
| spi_miso | input | 1 | SPI data from the SRAM |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench checks three kinds of corner case.

- **Delay length.** It runs a delay of three pages and a delay of zero, where a read targets the page that has just been written. An off-by-one in the read address, or in the time at which a page is switched in, shows up as every output sample moving by eight positions.
- **Zero output before playback.** The scoreboard expects zeros up to the exact strobe where the first page starts playing. A design that plays stale buffer contents, or starts one page early, fails there.
- **Underrun.** A phase with strobes too fast for the bursts must raise `underrun`. A design that flags it before playback starts, or never flags it, is reported.

The SRAM model checks each command's opcode, address, bit count, byte order and padding. It also checks the chip-select gap and the level of SCK when CS falls.

// File: rtl/sde_pkg.sv
package sde_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [1:0] {SP_IDLE, SP_SHIFT, SP_FIN, SP_GAP} spi_state_e;
  typedef enum logic [1:0] {SC_IDLE, SC_WR, SC_RD} sched_state_e;
endpackage

// File: rtl/sde_page_buf.sv
module sde_page_buf #(
  parameter int DW   = 24,
  parameter int PAGE = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic                        wbank,
  input  logic [$clog2(PAGE)-1:0]     widx,
  input  logic [DW-1:0]               wdata,
  input  logic                        rbank,
  input  logic [$clog2(PAGE)-1:0]     ridx,
  output logic [DW-1:0]               rdata
);
  localparam int IW    = $clog2(PAGE);
  localparam int DEPTH = 2 * PAGE;

  logic [DW-1:0] mem [DEPTH];

  // one synchronous write port, asynchronous read: maps to distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[{wbank, widx}] <= wdata;
  end

  assign rdata = mem[{rbank, ridx}];

  logic unused_w;
  assign unused_w = ^IW;
endmodule

// File: rtl/sde_spi_burst.sv
module sde_spi_burst
  import sde_pkg::*;
#(
  parameter int SW      = 24,
  parameter int PAGE    = 8,
  parameter int AW      = 16,
  parameter int GAP_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    rd_cmd,
  input  logic [AW-1:0]           addr,
  output logic                    busy,
  output logic                    done,
  output logic [$clog2(PAGE)-1:0] tx_idx,
  input  logic [SW-1:0]           tx_data,
  output logic                    rx_we,
  output logic [$clog2(PAGE)-1:0] rx_idx,
  output logic [SW-1:0]           rx_data,
  output logic                    sck,
  output logic                    mosi,
  output logic                    cs_n,
  input  logic                    miso
);
  localparam int WB   = 32;
  localparam int PADW = WB - SW;
  localparam int CMDW = 8 + AW;
  localparam int IW   = $clog2(PAGE);
  localparam int BCW  = $clog2(WB);
  localparam int GCW  = $clog2(GAP_CYC + 1);

  spi_state_e     st;
  logic [WB-1:0]  sh;
  logic [WB-1:0]  rx;
  logic [WB-1:0]  word_in;
  logic           hdr;
  logic           rdm;
  logic [BCW-1:0] bcnt;
  logic [IW-1:0]  widx;
  logic [GCW-1:0] gcnt;

  assign word_in = {rx[WB-2:0], miso};
  assign tx_idx  = hdr ? '0 : widx + IW'(1);
  assign mosi    = sh[WB-1];
  assign busy    = (st != SP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SP_IDLE;
      sh      <= '0;
      rx      <= '0;
      hdr     <= 1'b0;
      rdm     <= 1'b0;
      bcnt    <= '0;
      widx    <= '0;
      gcnt    <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
      rx_we   <= 1'b0;
      rx_idx  <= '0;
      rx_data <= '0;
    end else begin
      done  <= 1'b0;
      rx_we <= 1'b0;
      case (st)
        SP_IDLE: begin
          if (start) begin
            cs_n <= 1'b0;
            sh   <= {(rd_cmd ? OP_READ : OP_WRITE), addr, {(WB-CMDW){1'b0}}};
            hdr  <= 1'b1;
            rdm  <= rd_cmd;
            bcnt <= '0;
            widx <= '0;
            st   <= SP_SHIFT;
          end
        end
        SP_SHIFT: begin
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck  <= 1'b0;
            rx   <= word_in;
            sh   <= {sh[WB-2:0], 1'b0};
            bcnt <= bcnt + BCW'(1);
            if (hdr && bcnt == BCW'(CMDW-1)) begin
              hdr  <= 1'b0;
              bcnt <= '0;
              sh   <= rdm ? '0 : {tx_data, {PADW{1'b0}}};
            end else if (!hdr && bcnt == BCW'(WB-1)) begin
              bcnt    <= '0;
              rx_we   <= rdm;
              rx_idx  <= widx;
              rx_data <= word_in[WB-1 -: SW];
              if (widx == IW'(PAGE-1)) begin
                sh <= '0;
                st <= SP_FIN;
              end else begin
                widx <= widx + IW'(1);
                sh   <= rdm ? '0 : {tx_data, {PADW{1'b0}}};
              end
            end
          end
        end
        SP_FIN: begin
          cs_n <= 1'b1;
          gcnt <= '0;
          st   <= SP_GAP;
        end
        default: begin
          if (gcnt == GCW'(GAP_CYC-1)) begin
            done <= 1'b1;
            st   <= SP_IDLE;
          end else begin
            gcnt <= gcnt + GCW'(1);
          end
        end
      endcase
    end
  end

  // R2: clock idles low while the slave is deselected
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  // R2: data line holds across the rising edge
  a_r2_mosi_setup: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $rose(sck)) |-> $stable(mosi));
  // R7: deselect lasts beyond a single cycle
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
endmodule

// File: rtl/sde_sched.sv
module sde_sched
  import sde_pkg::*;
#(
  parameter int AW   = 16,
  parameter int PAGE = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   page_rdy,
  input  logic                                   page_bank,
  input  logic [AW-$clog2(PAGE*4)-1:0]           delay_pages,
  input  logic                                   spi_done,
  output logic                                   spi_start,
  output logic                                   spi_rd,
  output logic [AW-1:0]                          spi_addr,
  output logic                                   tx_bank,
  output logic                                   rd_done
);
  localparam int OFFW = $clog2(PAGE * 4);
  localparam int PCW  = AW - OFFW;

  sched_state_e   st;
  logic           pend;
  logic           pend_bank;
  logic           primed;
  logic [PCW-1:0] wpage;
  logic           issue;

  assign issue = (st == SC_IDLE) && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SC_IDLE;
      pend      <= 1'b0;
      pend_bank <= 1'b0;
      primed    <= 1'b0;
      wpage     <= '0;
      spi_start <= 1'b0;
      spi_rd    <= 1'b0;
      spi_addr  <= '0;
      tx_bank   <= 1'b0;
      rd_done   <= 1'b0;
    end else begin
      spi_start <= 1'b0;
      rd_done   <= 1'b0;
      if (page_rdy) begin
        pend      <= 1'b1;
        pend_bank <= page_bank;
      end else if (issue) begin
        pend <= 1'b0;
      end
      case (st)
        SC_IDLE: begin
          if (pend) begin
            spi_start <= 1'b1;
            spi_rd    <= 1'b0;
            spi_addr  <= {wpage, {OFFW{1'b0}}};
            tx_bank   <= pend_bank;
            st        <= SC_WR;
          end
        end
        SC_WR: begin
          if (spi_done) begin
            if (primed || wpage == delay_pages) begin
              primed    <= 1'b1;
              spi_start <= 1'b1;
              spi_rd    <= 1'b1;
              spi_addr  <= {wpage - delay_pages, {OFFW{1'b0}}};
              st        <= SC_RD;
            end else begin
              wpage <= wpage + PCW'(1);
              st    <= SC_IDLE;
            end
          end
        end
        default: begin
          if (spi_done) begin
            rd_done <= 1'b1;
            wpage   <= wpage + PCW'(1);
            st      <= SC_IDLE;
          end
        end
      endcase
    end
  end

  // R6: a read is only launched once enough pages have been stored
  a_r6_read_primed: assert property (@(posedge clk) disable iff (rst)
    (spi_start && spi_rd) |=> primed);
  // R5: write commands always start on a page boundary
  a_r5_page_aligned: assert property (@(posedge clk) disable iff (rst)
    spi_start |-> (spi_addr[OFFW-1:0] == '0));
endmodule

// File: rtl/sde_delay_engine.sv
module sde_delay_engine #(
  parameter int SW      = 24,
  parameter int PAGE    = 8,
  parameter int AW      = 16,
  parameter int GAP_CYC = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 smp_stb,
  input  logic [SW-1:0]                        smp_in,
  input  logic [AW-$clog2(PAGE*4)-1:0]         delay_pages,
  output logic [SW-1:0]                        smp_out,
  output logic                                 underrun,
  output logic                                 spi_sck,
  output logic                                 spi_mosi,
  input  logic                                 spi_miso,
  output logic                                 spi_cs_n
);
  localparam int IW = $clog2(PAGE);

  logic [IW-1:0] icnt;
  logic          ibank;
  logic          page_rdy;
  logic          rdy_bank;
  logic          play_bank;
  logic          play_ok;
  logic          ready;
  logic          started;
  logic          sel_bank;
  logic          boundary;

  logic          spi_start, spi_rd, spi_busy, spi_done, tx_bank, rd_done;
  logic [AW-1:0] spi_addr;
  logic [IW-1:0] tx_idx, rx_idx;
  logic [SW-1:0] tx_data, rx_data, obuf_q;
  logic          rx_we;

  assign boundary = smp_stb && (icnt == '0);
  assign sel_bank = (icnt == '0 && ready) ? ~play_bank : play_bank;

  sde_page_buf #(.DW(SW), .PAGE(PAGE)) u_ibuf (
    .clk(clk), .we(smp_stb), .wbank(ibank), .widx(icnt), .wdata(smp_in),
    .rbank(tx_bank), .ridx(tx_idx), .rdata(tx_data));

  sde_page_buf #(.DW(SW), .PAGE(PAGE)) u_obuf (
    .clk(clk), .we(rx_we), .wbank(~play_bank), .widx(rx_idx), .wdata(rx_data),
    .rbank(sel_bank), .ridx(icnt), .rdata(obuf_q));

  sde_sched #(.AW(AW), .PAGE(PAGE)) u_sched (
    .clk(clk), .rst(rst), .page_rdy(page_rdy), .page_bank(rdy_bank),
    .delay_pages(delay_pages), .spi_done(spi_done), .spi_start(spi_start),
    .spi_rd(spi_rd), .spi_addr(spi_addr), .tx_bank(tx_bank), .rd_done(rd_done));

  sde_spi_burst #(.SW(SW), .PAGE(PAGE), .AW(AW), .GAP_CYC(GAP_CYC)) u_spi (
    .clk(clk), .rst(rst), .start(spi_start), .rd_cmd(spi_rd), .addr(spi_addr),
    .busy(spi_busy), .done(spi_done), .tx_idx(tx_idx), .tx_data(tx_data),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data), .sck(spi_sck),
    .mosi(spi_mosi), .cs_n(spi_cs_n), .miso(spi_miso));

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt      <= '0;
      ibank     <= 1'b0;
      page_rdy  <= 1'b0;
      rdy_bank  <= 1'b0;
      play_bank <= 1'b0;
      play_ok   <= 1'b0;
      ready     <= 1'b0;
      started   <= 1'b0;
      smp_out   <= '0;
      underrun  <= 1'b0;
    end else begin
      page_rdy <= 1'b0;
      underrun <= 1'b0;
      ready    <= rd_done | (ready & !boundary);
      if (smp_stb) begin
        icnt <= icnt + IW'(1);
        if (icnt == IW'(PAGE-1)) begin
          ibank    <= ~ibank;
          page_rdy <= 1'b1;
          rdy_bank <= ibank;
        end
        if (icnt == '0) begin
          if (ready) begin
            play_bank <= ~play_bank;
            play_ok   <= 1'b1;
            started   <= 1'b1;
            smp_out   <= obuf_q;
          end else begin
            play_ok  <= 1'b0;
            smp_out  <= '0;
            underrun <= started;
          end
        end else if (play_ok) begin
          smp_out <= obuf_q;
        end else begin
          smp_out  <= '0;
          underrun <= started;
        end
      end
    end
  end

  // R9: silence until the first delayed page plays
  a_r9_silent_before_play: assert property (@(posedge clk) disable iff (rst)
    !started |-> (smp_out == '0));
  // R10: no underrun report before playback begins
  a_r10_underrun_after_start: assert property (@(posedge clk) disable iff (rst)
    underrun |-> started);
  // R8: output moves only on a strobe
  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(smp_out));
  // R3: a burst is never launched over another one
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    spi_start |-> !spi_busy);
endmodule

// File: tb/sim_sde_delay_engine.sv
module sim_sde_delay_engine;
  localparam int SW      = 24;
  localparam int PAGE    = 8;
  localparam int AW      = 16;
  localparam int GAP_CYC = 4;
  localparam int PCW     = 11;
  localparam int PER     = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic [SW-1:0] din = '0;
  logic [PCW-1:0] dly = '0;
  logic [SW-1:0] dout;
  logic underrun, sck, mosi, cs_n;
  logic miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sde_delay_engine #(.SW(SW), .PAGE(PAGE), .AW(AW), .GAP_CYC(GAP_CYC)) u0 (
    .clk(clk), .rst(rst), .smp_stb(stb), .smp_in(din), .delay_pages(dly),
    .smp_out(dout), .underrun(underrun), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  int exp_q[$];
  bit pre_q[$];
  int hist[$];
  int sent[$];
  int kglob = 0;
  bit cmp_en = 1;
  bit data_chk = 1;
  int nund = 0;
  logic seen = 1'b0;

  always @(posedge clk) seen <= stb;

  always @(negedge clk) begin
    if (seen) begin
      if (cmp_en && exp_q.size() > 0) begin
        int e;
        bit pre;
        e = exp_q.pop_front();
        pre = pre_q.pop_front();
        if (pre) chk(dout == SW'(e), "R9 zero before playback", int'(dout), e);
        else     chk(dout == SW'(e), "R8 delayed sample", int'(dout), e);
        chk(underrun == 1'b0, "R10 no underrun at normal rate", int'(underrun), 0);
      end else if (!cmp_en && underrun) begin
        nund++;
      end
    end
  end

  function automatic int pattern(input int sel, input int k);
    case (sel)
      0: return (k * 24'h010203) & 24'hFFFFFF;
      1: return $urandom & 24'hFFFFFF;
      2: return (k % 2) ? 24'hAAAAAA : 24'h555555;
      default: return (k % 3 == 0) ? 24'hFFFFFF : ((k % 3 == 1) ? 24'h800000 : 24'h000001);
    endcase
  endfunction

  task automatic send(input int n, input int per, input int sel);
    for (int i = 0; i < n; i++) begin
      int v;
      int lat;
      lat = 8 * (int'(dly) + 2);
      v = pattern(sel, kglob);
      @(negedge clk);
      stb = 1'b1;
      din = SW'(v);
      sent.push_back(v);
      hist.push_back(v);
      if (hist.size() > lat) begin
        exp_q.push_back(hist.pop_front());
        pre_q.push_back(1'b0);
      end else begin
        exp_q.push_back(0);
        pre_q.push_back(1'b1);
      end
      kglob++;
      @(negedge clk);
      stb = 1'b0;
      repeat (per - 2) @(negedge clk);
    end
  endtask

  // ---------------- SRAM model ----------------
  logic [7:0] mem [int];
  int bitn, nbytes, totbits, obit;
  logic [7:0] shb, op, ob;
  logic [15:0] maddr, raddr;
  bit rdm = 0;
  bit cmd_open = 0;
  int ewp = 0;
  int lastwp = 0;
  bit want_rd = 0;

  task automatic cmd_check();
    if (op == 8'h02) begin
      chk(maddr == 16'(ewp * 32), "R5 write address", int'(maddr), (ewp * 32) & 16'hFFFF);
      chk(!want_rd, "R6 read missing after write", int'(want_rd), 0);
      lastwp = ewp;
      ewp++;
      want_rd = (lastwp >= int'(dly));
    end else if (op == 8'h03) begin
      chk(want_rd, "R6 read only after eligible write", int'(want_rd), 1);
      chk(maddr == 16'((lastwp - int'(dly)) * 32), "R6 read address", int'(maddr),
          ((lastwp - int'(dly)) * 32) & 16'hFFFF);
      want_rd = 0;
      raddr = maddr;
    end else begin
      chk(1'b0, "R3 opcode", int'(op), 2);
    end
  endtask

  task automatic byte_done(input logic [7:0] b);
    if (nbytes == 0) op = b;
    else if (nbytes == 1) maddr[15:8] = b;
    else if (nbytes == 2) begin
      maddr[7:0] = b;
      cmd_check();
      if (op == 8'h03) rdm = 1;
    end else if (op == 8'h02) begin
      int bi, si;
      bi = int'(maddr) % 4;
      si = (int'(maddr) / 32) * 8 + (int'(maddr) % 32) / 4;
      if (data_chk && si < sent.size()) begin
        int s, e;
        s = sent[si];
        e = (bi == 0) ? ((s >> 16) & 255) : (bi == 1) ? ((s >> 8) & 255) :
            (bi == 2) ? (s & 255) : 0;
        chk(b == 8'(e), "R4 stored byte", int'(b), e);
      end
      mem[int'(maddr)] = b;
      maddr = maddr + 16'd1;
    end
    nbytes++;
  endtask

  always @(negedge cs_n) begin
    chk(sck == 1'b0, "R2 SCK low at select", int'(sck), 0);
    bitn = 0; nbytes = 0; totbits = 0; obit = 0; rdm = 0; cmd_open = 1;
  end

  always @(posedge cs_n) begin
    if (cmd_open) chk(totbits == 280, "R3 bits per command", totbits, 280);
    cmd_open = 0;
    rdm = 0;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      shb = {shb[6:0], mosi};
      bitn++;
      totbits++;
      if (bitn == 8) begin
        bitn = 0;
        byte_done(shb);
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n && rdm) begin
      if (obit == 0) begin
        ob = mem.exists(int'(raddr)) ? mem[int'(raddr)] : 8'h00;
        raddr = raddr + 16'd1;
      end
      miso = ob[7 - obit];
      obit = (obit + 1) % 8;
    end
  end

  // ---------------- CS gap monitor ----------------
  int hc = 0;
  bit cs_seen = 0;
  always @(posedge clk) begin
    if (rst) begin
      hc = 0;
      cs_seen = 0;
    end else if (cs_n) begin
      hc++;
    end else begin
      if (hc > 0 && cs_seen) chk(hc >= GAP_CYC, "R7 CS gap", hc, GAP_CYC);
      cs_seen = 1;
      hc = 0;
    end
  end

  // ---------------- phases ----------------
  task automatic do_reset(input int d);
    rst = 1'b1;
    dly = PCW'(d);
    repeat (5) @(negedge clk);
    chk(dout == '0, "R1 output in reset", int'(dout), 0);
    chk(underrun == 1'b0, "R1 underrun in reset", int'(underrun), 0);
    chk(cs_n == 1'b1, "R1 CS in reset", int'(cs_n), 1);
    chk(sck == 1'b0 && mosi == 1'b0, "R1 SPI lines in reset", int'({sck, mosi}), 0);
    mem.delete();
    hist.delete(); sent.delete(); exp_q.delete(); pre_q.delete();
    kglob = 0; ewp = 0; lastwp = 0; want_rd = 0; cmd_open = 0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset(3);
    send(40, PER, 0);
    send(40, PER, 1);
    send(24, PER, 2);
    send(24, PER, 3);
    repeat (3000) @(negedge clk);

    do_reset(0);
    send(24, PER, 3);
    send(24, PER, 1);
    repeat (3000) @(negedge clk);

    do_reset(1);
    cmp_en = 0;
    data_chk = 0;
    send(96, 40, 1);
    repeat (4000) @(negedge clk);
    chk(nund > 0, "R10 underrun at excessive rate", nund, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule